// File: doc/BRIEF.md
# Multiframe Q-Channel Receive Capture

This block gathers the four Q-channel bits that arrive spread across one received S/T-interface multiframe. It presents them to a microcontroller as a read-only 8-bit value. The line decoder and the multiframe alignment search sit upstream. For every received frame they provide a one-cycle frame strobe, the frame's position inside the 20-frame multiframe, a sync-valid indication and the extracted Q bit.

Q bits are first assembled in a hidden shadow word. The visible value changes in a single step, and only once the last Q bit of a correctly ordered multiframe has arrived, so a reader never sees a mixture of two messages. Each completed message sets a sticky interrupt flag, and a register read clears it. After a message is published, the value is frozen for a guard window of frames, which gives the processor a safe period in which to read it. While multiframing is switched off, the value reads as all ones.

Top module: `mfq_capture`

## Requirements
- R1: The read value is 8 bits wide. Bits 7..4 always read 0, and bits 3..0 hold the message with Q1 in bit 3, Q2 in bit 2, Q3 in bit 1 and Q4 in bit 0.
- R2: Q bits are sampled only on frame strobes at multiframe positions 0, 5, 10 and 15, which carry Q1, Q2, Q3 and Q4 in that order. The Q input at every other position has no effect.
- R3: The visible value changes only in the clock after the strobe that delivers Q4, and only when Q1, Q2 and Q3 of the same multiframe were collected in order before it. Reading part-way through a multiframe returns the previous complete message.
- R4: A frame strobe with sync-valid low discards the bits collected so far. A later Q3 or Q4 then publishes nothing, and the old value is kept.
- R5: While multiframing is disabled, the value reads 0x0F, the flag is held low and collection restarts. After it is enabled again, the value stays at 0x0F until a full message is received.
- R6: Publishing a message sets the interrupt flag in the same clock edge. The flag stays set until a read, even across idle cycles.
- R7: A read clears the flag at the next clock edge. If a publish happens in the same cycle as the read, the flag stays set.
- R8: After a publish, a completed message that ends within the next 19 frame strobes is discarded: the value and the flag are unchanged. A message ending on the 20th strobe or later is published.
- R9: After reset, the value reads 0x0F and the flag is low.
- R10: A Q bit at a later slot position that arrives without the preceding slots of its multiframe (for example Q3 and Q4 alone) publishes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| mf_pos | input | 5 | Position of this frame in the multiframe, 0..19 |
| mf_sync | input | 1 | Multiframe alignment is valid for this frame |
| q_bit | input | 1 | Q-channel bit extracted from this frame |
| mf_enable | input | 1 | Multiframing enable |
| rd_en | input | 1 | Register read strobe (clears the flag) |
| rd_data | output | 8 | Register value |
| q_irq | output | 1 | Sticky new-message flag |

## Verification
A wrong collection count or a stale shadow bit does not show up at once. It appears only at the next Q4 strobe, where rd_data either fails to change or takes on a mix of old and new bits. The tests therefore always finish a multiframe after each disturbance and compare the value one cycle after that strobe. A wrong guard counter shows up as a publish or a missing publish on one specific strobe, so the window is tested with messages that end both inside and exactly at its edge. Flag errors show within one clock of a read or a publish.

// File: rtl/mfq_pkg.sv
package mfq_pkg;

    localparam int unsigned QBITS  = 4;
    localparam int unsigned RD_W   = 8;
    localparam int unsigned SLOT_W = $clog2(QBITS);

    typedef logic [QBITS-1:0]  qword_t;
    typedef logic [RD_W-1:0]   rdword_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;

    // Decoded Q slot of the current frame
    typedef struct packed {
        logic      hit;
        slot_idx_t idx;
    } slot_t;

    // Completed message offered for publication
    typedef struct packed {
        logic   valid;
        qword_t word;
    } qmsg_t;

    // Slot 0 (first received) lands in the most significant bit
    function automatic qword_t place_bit(qword_t w, slot_idx_t idx, logic b);
        qword_t r;
        r = w;
        r[QBITS-1-int'(idx)] = b;
        return r;
    endfunction

    function automatic rdword_t pack_rd(qword_t q);
        return {{(RD_W-QBITS){1'b0}}, q};
    endfunction

endpackage

// File: rtl/mfq_slot_decode.sv
module mfq_slot_decode
    import mfq_pkg::*;
#(
    parameter int unsigned POS_W     = 5,
    parameter int unsigned Q_SPACING = 5
) (
    input  logic [POS_W-1:0] pos,
    output slot_t            slot
);

    logic [QBITS-1:0] hits;

    for (genvar k = 0; k < QBITS; k++) begin : g_slot
        localparam logic [POS_W-1:0] SLOT_POS = POS_W'(k * Q_SPACING);
        assign hits[k] = (pos == SLOT_POS);
    end

    always_comb begin
        slot = '0;
        for (int k = 0; k < QBITS; k++) begin
            if (hits[k]) begin
                slot.hit = 1'b1;
                slot.idx = SLOT_W'(k);
            end
        end
    end

endmodule

// File: rtl/mfq_shadow.sv
module mfq_shadow
    import mfq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  stb,
    input  logic  sync,
    input  logic  q,
    input  slot_t slot,
    output qmsg_t msg
);

    localparam slot_idx_t LAST = SLOT_W'(QBITS - 1);

    slot_idx_t fill, fill_n;
    qword_t    shadow, shadow_n;

    always_comb begin
        fill_n   = fill;
        shadow_n = shadow;
        msg      = '0;
        if (!en) begin
            fill_n = '0;
        end else if (stb) begin
            if (!sync) begin
                fill_n = '0;
            end else if (slot.hit) begin
                if (slot.idx == '0) begin
                    shadow_n = place_bit('1, '0, q);
                    fill_n   = SLOT_W'(1);
                end else if (slot.idx == fill) begin
                    shadow_n = place_bit(shadow, slot.idx, q);
                    if (slot.idx == LAST) begin
                        msg.valid = 1'b1;
                        msg.word  = shadow_n;
                        fill_n    = '0;
                    end else begin
                        fill_n = fill + 1'b1;
                    end
                end else begin
                    fill_n = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill   <= '0;
            shadow <= '1;
        end else begin
            fill   <= fill_n;
            shadow <= shadow_n;
        end
    end

    // R4: a strobe without sync leaves nothing collected
    assert_sync_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (stb && !sync) |=> (fill == '0));

    // R10: a publish is only offered with the preceding slots collected
    assert_ordered_R10: assert property (@(posedge clk) disable iff (rst)
        msg.valid |-> (fill == LAST));

endmodule

// File: rtl/mfq_hold.sv
module mfq_hold
    import mfq_pkg::*;
#(
    parameter int unsigned HOLD_FRAMES = 20
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   stb,
    input  logic   rd,
    input  qmsg_t  msg,
    output qword_t visible,
    output logic   irq
);

    localparam int unsigned CNT_W = $clog2(HOLD_FRAMES);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_FRAMES - 1);

    logic [CNT_W-1:0] since;
    logic             publish;

    assign publish = en && stb && msg.valid && (since >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            visible <= '1;
            irq     <= 1'b0;
            since   <= LIMIT;
        end else begin
            if (publish) begin
                visible <= msg.word;
                since   <= '0;
            end else if (stb && since < LIMIT) begin
                since <= since + 1'b1;
            end
            if (publish)  irq <= 1'b1;
            else if (rd)  irq <= 1'b0;
        end
    end

    // R8: value frozen while the guard window is open
    assert_hold_window_R8: assert property (@(posedge clk) disable iff (rst)
        (en && since < LIMIT) |=> (!en || $stable(visible)));

    // R3: value only moves on a frame strobe
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !stb) |=> (!en || $stable(visible)));

    // R5: disabled forces all ones and no flag
    assert_disabled_ones_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (visible == '1 && !irq));

endmodule

// File: rtl/mfq_capture.sv
module mfq_capture
    import mfq_pkg::*;
#(
    parameter int unsigned MF_FRAMES   = 20,
    parameter int unsigned Q_SPACING   = 5,
    parameter int unsigned HOLD_FRAMES = 20,
    localparam int unsigned POS_W      = $clog2(MF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [POS_W-1:0] mf_pos,
    input  logic             mf_sync,
    input  logic             q_bit,
    input  logic             mf_enable,
    input  logic             rd_en,
    output logic [RD_W-1:0]  rd_data,
    output logic             q_irq
);

    slot_t  slot;
    qmsg_t  msg;
    qword_t visible;

    mfq_slot_decode #(
        .POS_W     (POS_W),
        .Q_SPACING (Q_SPACING)
    ) u_decode (
        .pos  (mf_pos),
        .slot (slot)
    );

    mfq_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .en   (mf_enable),
        .stb  (frame_stb),
        .sync (mf_sync),
        .q    (q_bit),
        .slot (slot),
        .msg  (msg)
    );

    mfq_hold #(
        .HOLD_FRAMES (HOLD_FRAMES)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .en      (mf_enable),
        .stb     (frame_stb),
        .rd      (rd_en),
        .msg     (msg),
        .visible (visible),
        .irq     (q_irq)
    );

    assign rd_data = pack_rd(visible);

    // R7: a read with no frame strobe leaves the flag clear
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !frame_stb) |=> !q_irq);

    // R6: the flag only rises on an enabled frame strobe
    assert_irq_on_frame_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(q_irq) |-> $past(frame_stb && mf_enable));

    // R1: reserved bits stay zero
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[RD_W-1:QBITS] == '0);

endmodule

// File: tb/mfq_capture_bench.sv
module mfq_capture_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_stb;
    logic [4:0] mf_pos;
    logic       mf_sync;
    logic       q_bit;
    logic       mf_enable;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       q_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mfq_capture u_mfq_capture (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mf_pos    (mf_pos),
        .mf_sync   (mf_sync),
        .q_bit     (q_bit),
        .mf_enable (mf_enable),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .q_irq     (q_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_val(input string req, input logic [7:0] exp);
        check(rd_data === exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic check_irq(input string req, input logic exp);
        check(q_irq === exp, req, int'(q_irq), int'(exp));
    endtask

    // Q bit a frame carries for a given message; filler elsewhere
    function automatic logic qbit_for(input logic [3:0] w, input int p);
        if (p % 5 == 0 && p / 5 < 4) return w[3 - p / 5];
        return ~w[p % 4];
    endfunction

    task automatic strobe(input int p, input logic q, input logic s);
        @(negedge clk);
        frame_stb = 1'b1;
        mf_pos    = 5'(p);
        q_bit     = q;
        mf_sync   = s;
        @(negedge clk);
        frame_stb = 1'b0;
        q_bit     = 1'b0;
    endtask

    task automatic send_range(input logic [3:0] w, input int from, input int to);
        for (int p = from; p <= to; p++) strobe(p, qbit_for(w, p), 1'b1);
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        v     = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        check_val("R9 reset value", 8'h0F);
        check_irq("R9 reset flag", 1'b0);
    endtask

    task automatic t_basic;
        logic [7:0] v;
        send_range(4'b1010, 0, 19);
        check_val("R1 R2 bit order", 8'h0A);
        check_irq("R6 flag set", 1'b1);
        repeat (5) @(negedge clk);
        check_irq("R6 flag sticky", 1'b1);
        do_read(v);
        check(v === 8'h0A, "R1 read data", int'(v), 8'h0A);
        check_irq("R7 read clears", 1'b0);
    endtask

    task automatic t_partial;
        logic [7:0] v;
        send_range(4'b0101, 0, 12);
        do_read(v);
        check(v === 8'h0A, "R3 mid-multiframe read", int'(v), 8'h0A);
        send_range(4'b0101, 13, 14);
        check_val("R3 before Q4", 8'h0A);
        send_range(4'b0101, 15, 15);
        check_val("R3 publish on Q4", 8'h05);
        check_irq("R3 flag on Q4", 1'b1);
        send_range(4'b0101, 16, 19);
        do_read(v);
    endtask

    task automatic t_sync_loss;
        send_range(4'b0011, 0, 7);
        strobe(8, 1'b0, 1'b0);
        send_range(4'b0011, 9, 19);
        check_val("R4 sync loss keeps value", 8'h05);
        check_irq("R4 sync loss no flag", 1'b0);
    endtask

    task automatic t_out_of_order;
        strobe(10, 1'b0, 1'b1);
        strobe(15, 1'b0, 1'b1);
        check_val("R10 missing slots", 8'h05);
        check_irq("R10 missing slots flag", 1'b0);
        send_range(4'b0000, 16, 19);
    endtask

    task automatic t_window;
        logic [7:0] v;
        send_range(4'b1100, 0, 19);
        check_val("R8 first publish", 8'h0C);
        do_read(v);
        strobe(0, 1'b0, 1'b1);
        strobe(5, 1'b0, 1'b1);
        strobe(10, 1'b1, 1'b1);
        strobe(15, 1'b1, 1'b1);
        check_val("R8 inside window", 8'h0C);
        check_irq("R8 inside window flag", 1'b0);
        send_range(4'b0110, 0, 15);
        check_val("R8 after window", 8'h06);
        check_irq("R8 after window flag", 1'b1);
        send_range(4'b0110, 16, 19);
        do_read(v);
    endtask

    task automatic t_read_vs_publish;
        send_range(4'b1001, 0, 14);
        @(negedge clk);
        frame_stb = 1'b1;
        mf_pos    = 5'd15;
        q_bit     = 1'b1;
        mf_sync   = 1'b1;
        rd_en     = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        rd_en     = 1'b0;
        check_irq("R7 publish beats read", 1'b1);
        check_val("R7 value on collision", 8'h09);
        send_range(4'b1001, 16, 19);
    endtask

    task automatic t_disable;
        logic [7:0] v;
        @(negedge clk);
        mf_enable = 1'b0;
        @(negedge clk);
        check_val("R5 disabled value", 8'h0F);
        check_irq("R5 disabled flag", 1'b0);
        send_range(4'b0000, 0, 19);
        check_val("R5 disabled ignores frames", 8'h0F);
        check_irq("R5 disabled no flag", 1'b0);
        mf_enable = 1'b1;
        send_range(4'b0000, 5, 19);
        check_val("R5 re-enable no partial", 8'h0F);
        send_range(4'b0011, 0, 19);
        check_val("R5 resumes", 8'h03);
        check_irq("R5 resumes flag", 1'b1);
        do_read(v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        frame_stb = 1'b0;
        mf_pos    = '0;
        mf_sync   = 1'b1;
        q_bit     = 1'b0;
        mf_enable = 1'b1;
        rd_en     = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_partial();
        t_sync_loss();
        t_out_of_order();
        t_window();
        t_read_vs_publish();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule